// File: doc/BRIEF.md
# CAN Interrupt and Error-State Controller

This block gathers every event a CAN node reports to its host and turns it into one interrupt line. Sixteen mailbox ready levels, four node error-state levels and five sticky frame-error flags form a 29-bit event word. The host enables or disables interrupt sources with two write-only registers: one sets bits of the interrupt mask and the other clears them. A third register reads the mask back. The interrupt line is high whenever an event bit and its mask bit are both set.

The protocol engine supplies the receive and transmit error counts. The block registers them and derives the node error state from them, and it shows both counts in an error-count register. Bus-off is latched and stays set until the engine signals recovery. A read of the event word clears the frame-error flags. A frame error that arrives in the same cycle as that read is kept, so it is never lost.

Top module: `can_irq_ctrl`

## Requirements
- R1: After reset the mask reads 0, the error-count register reads 0, the event word reads only bit 16 (error-active), `node_state_o` is 0 and `irq_o` is low.
- R2: Event bits 15:0 follow the `mb_ready_i` levels directly.
- R3: A one-cycle pulse on `frame_err_i` sets a sticky event bit: input bit 0 (CRC) sets bit 24, bit 1 (stuffing) sets 25, bit 2 (acknowledge) sets 26, bit 3 (form) sets 27 and bit 4 (bit error) sets 28.
- R4: A read of the event word (address 3) returns its value in `reg_rdata_o` one cycle after the read strobe, and it clears bits 28:24. Bits 19:0 are not affected by the read.
- R5: A frame-error pulse in the same cycle as an event-word read is not in that read's result, and its bit is still set after the read.
- R6: A write to address 0 sets the mask bits where `reg_wdata_i` is 1. A write to address 1 clears them. The other mask bits are unchanged. A read of address 2 returns the 29-bit mask.
- R7: `irq_o` is high exactly when the event word AND the mask is non-zero. It changes in the same cycle as the event or mask bit that causes it.
- R8: A read of address 4 returns the registered receive count in bits 7:0 and the low 8 bits of the transmit count in bits 23:16. All other bits are zero. A count applied before a clock edge is visible from that edge on.
- R9: Event bit 17 (warning) is set when either count is 96 or more. Bit 18 (error-passive) is set when either count is 128 or more. Bit 16 (error-active) is set only when none of bits 17 to 19 is set.
- R10: Bit 19 (bus-off) is set once the 9-bit transmit count reaches 256. It stays set until `bus_recover_i` pulses while the transmit count is below 256.
- R11: `node_state_o` gives the highest active state in priority order: 3 bus-off, then 2 error-passive, then 1 warning, else 0 error-active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mb_ready_i | input | 16 | Per-mailbox ready levels |
| frame_err_i | input | 5 | Frame-error pulses: CRC, stuffing, acknowledge, form, bit |
| rec_i | input | 8 | Receive error count from the protocol engine |
| tec_i | input | 9 | Transmit error count from the protocol engine |
| bus_recover_i | input | 1 | Pulse that releases the bus-off latch |
| reg_addr_i | input | 3 | Register word address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |
| node_state_o | output | 2 | Encoded node error state |

## Verification
A frame-error pulse and a clear-on-read of the event word can land in the same clock cycle. The bench provokes this by raising the bit-error input in the very cycle that the read strobe is high. It then judges two things. The returned word must not contain that flag. A second read must show the flag, and a third read must show it cleared. The bench also releases bus-off while the transmit count is still at or above 256, and checks that bus-off holds.

// File: rtl/can_irq_pkg.sv
// Package: shared constants for the CAN interrupt and error-state controller.
// Assumes a 32-bit register port and a fixed 29-bit event word layout.
package can_irq_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 3;
    localparam int STAT_W   = 29;
    localparam int MB_N     = 16;
    localparam int LVL_N    = 4;
    localparam int FERR_N   = 5;
    localparam int LVL_LSB  = 16;
    localparam int FERR_LSB = 24;
    localparam int TEC_LSB  = 16;

    localparam logic [ADDR_W-1:0] ADR_MASK_SET = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MASK_CLR = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MASK     = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_STATUS   = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_ERRCNT   = 3'd4;

    typedef enum logic [1:0] {
        NODE_ACTIVE  = 2'd0,
        NODE_WARN    = 2'd1,
        NODE_PASSIVE = 2'd2,
        NODE_BUSOFF  = 2'd3
    } node_state_e;
endpackage

// File: rtl/can_err_state.sv
// Module: registers the error counts and derives the error-state levels.
// Level order in lvl_o: [0] active, [1] warning, [2] passive, [3] bus-off.
// Assumes the transmit count carries one extra bit, which flags the bus-off limit.
module can_err_state
    import can_irq_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int WARN_LVL = 96,
    parameter int PASS_LVL = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rec_i,
    input  logic [CNT_W:0]   tec_i,
    input  logic             recover_i,
    output logic [CNT_W-1:0] rec_o,
    output logic [CNT_W:0]   tec_o,
    output logic [LVL_N-1:0] lvl_o,
    output node_state_e      state_o
);
    localparam logic [CNT_W:0] WARN_V = (CNT_W+1)'(WARN_LVL);
    localparam logic [CNT_W:0] PASS_V = (CNT_W+1)'(PASS_LVL);

    logic [CNT_W-1:0] rec_q;
    logic [CNT_W:0]   tec_q;
    logic             busoff_q;
    logic             warn, passive;

    // Capture the counts supplied by the protocol engine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_q <= '0;
            tec_q <= '0;
        end else begin
            rec_q <= rec_i;
            tec_q <= tec_i;
        end
    end

    // Latch bus-off at the limit; release only on recovery below the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busoff_q <= 1'b0;
        else
            busoff_q <= tec_i[CNT_W] | (busoff_q & ~recover_i);
    end

    // Threshold compare of the registered counts.
    always_comb begin
        warn    = ({1'b0, rec_q} >= WARN_V) || (tec_q >= WARN_V);
        passive = ({1'b0, rec_q} >= PASS_V) || (tec_q >= PASS_V);
        lvl_o   = {busoff_q, passive, warn, ~(busoff_q | passive | warn)};
    end

    // Priority encode the node state.
    always_comb begin
        if (busoff_q)     state_o = NODE_BUSOFF;
        else if (passive) state_o = NODE_PASSIVE;
        else if (warn)    state_o = NODE_WARN;
        else              state_o = NODE_ACTIVE;
    end

    assign rec_o = rec_q;
    assign tec_o = tec_q;

    assert_busoff_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busoff_q && !recover_i) |=> busoff_q);
    assert_busoff_prio_R11: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_o[3] |-> (state_o == NODE_BUSOFF));
endmodule

// File: rtl/can_evt_status.sv
// Module: builds the 29-bit event word from levels and sticky frame-error flags.
// Assumes rd_clr_i is high for one cycle per read of the event word.
module can_evt_status
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MB_N-1:0]   mb_i,
    input  logic [LVL_N-1:0]  lvl_i,
    input  logic [FERR_N-1:0] ferr_i,
    input  logic              rd_clr_i,
    output logic [STAT_W-1:0] status_o
);
    logic [FERR_N-1:0] sticky_q;

    // Set on a pulse, clear on read; a pulse in the read cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
        end else begin
            for (int i = 0; i < FERR_N; i++) begin
                if (ferr_i[i])     sticky_q[i] <= 1'b1;
                else if (rd_clr_i) sticky_q[i] <= 1'b0;
            end
        end
    end

    // Place every source at its fixed bit position.
    always_comb begin
        status_o = '0;
        status_o[MB_N-1:0]             = mb_i;
        status_o[LVL_LSB +: LVL_N]     = lvl_i;
        status_o[FERR_LSB +: FERR_N]   = sticky_q;
    end

    for (genvar g = 0; g < FERR_N; g++) begin : g_chk
        assert_sticky_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (sticky_q[g] && !rd_clr_i) |=> sticky_q[g]);
        assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr_i && !ferr_i[g]) |=> !status_o[FERR_LSB+g]);
        assert_pulse_survives_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_clr_i && ferr_i[g]) |=> status_o[FERR_LSB+g]);
    end
endmodule

// File: rtl/can_irq_mask.sv
// Module: interrupt mask with separate set-only and clear-only writes.
// Assumes set_i and clr_i are never high together (one address per access).
module can_irq_mask
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] mask_o
);
    logic [STAT_W-1:0] mask_q;

    // Apply set and clear bit patterns to the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else
            mask_q <= (mask_q | (set_i ? wdata_i : '0)) & ~(clr_i ? wdata_i : '0);
    end

    assign mask_o = mask_q;

    for (genvar g = 0; g < STAT_W; g++) begin : g_chk
        assert_set_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (set_i && wdata_i[g]) |=> mask_o[g]);
        assert_clr_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && wdata_i[g]) |=> !mask_o[g]);
    end
endmodule

// File: rtl/can_irq_ctrl.sv
// Module: top of the CAN interrupt and error-state controller.
// Decodes the register port, registers the read data and drives the interrupt.
// Assumes at most one of reg_wr_i and reg_rd_i per cycle.
module can_irq_ctrl
    import can_irq_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int WARN_LVL = 96,
    parameter int PASS_LVL = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MB_N-1:0]   mb_ready_i,
    input  logic [FERR_N-1:0] frame_err_i,
    input  logic [CNT_W-1:0]  rec_i,
    input  logic [CNT_W:0]    tec_i,
    input  logic              bus_recover_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o,
    output logic [1:0]        node_state_o
);
    logic [CNT_W-1:0]  rec_v;
    logic [CNT_W:0]    tec_v;
    logic [LVL_N-1:0]  lvl;
    node_state_e       state;
    logic [STAT_W-1:0] status, mask;
    logic [DATA_W-1:0] errcnt_word, rdata_q;
    logic              rd_clr, mask_set, mask_clr;

    // Decode the strobes that reach the submodules.
    always_comb begin
        rd_clr   = reg_rd_i && (reg_addr_i == ADR_STATUS);
        mask_set = reg_wr_i && (reg_addr_i == ADR_MASK_SET);
        mask_clr = reg_wr_i && (reg_addr_i == ADR_MASK_CLR);
    end

    can_err_state #(.CNT_W(CNT_W), .WARN_LVL(WARN_LVL), .PASS_LVL(PASS_LVL)) u_state (
        .clk(clk), .rst_n(rst_n), .rec_i(rec_i), .tec_i(tec_i),
        .recover_i(bus_recover_i), .rec_o(rec_v), .tec_o(tec_v),
        .lvl_o(lvl), .state_o(state)
    );

    can_evt_status u_status (
        .clk(clk), .rst_n(rst_n), .mb_i(mb_ready_i), .lvl_i(lvl),
        .ferr_i(frame_err_i), .rd_clr_i(rd_clr), .status_o(status)
    );

    can_irq_mask u_mask (
        .clk(clk), .rst_n(rst_n), .set_i(mask_set), .clr_i(mask_clr),
        .wdata_i(reg_wdata_i[STAT_W-1:0]), .mask_o(mask)
    );

    // Pack the two counts into the error-count word.
    always_comb begin
        errcnt_word = '0;
        errcnt_word[CNT_W-1:0]        = rec_v;
        errcnt_word[TEC_LSB +: CNT_W] = tec_v[CNT_W-1:0];
    end

    // Register the selected read word on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (reg_rd_i) begin
            case (reg_addr_i)
                ADR_MASK:   rdata_q <= {{(DATA_W-STAT_W){1'b0}}, mask};
                ADR_STATUS: rdata_q <= {{(DATA_W-STAT_W){1'b0}}, status};
                ADR_ERRCNT: rdata_q <= errcnt_word;
                default:    rdata_q <= '0;
            endcase
        end
    end

    assign reg_rdata_o  = rdata_q;
    assign irq_o        = |(status & mask);
    assign node_state_o = state;

    assert_irq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq_o);
    assert_active_alone_R9: assert property (@(posedge clk) disable iff (!rst_n)
        status[LVL_LSB] |-> (status[LVL_LSB+3:LVL_LSB+1] == 3'b000));
endmodule

// File: tb/test_can_irq_ctrl.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares results.
module test_can_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mb_ready_i = '0;
    logic [4:0]  frame_err_i = '0;
    logic [7:0]  rec_i = '0;
    logic [8:0]  tec_i = '0;
    logic        bus_recover_i = 1'b0;
    logic [2:0]  reg_addr_i = '0;
    logic        reg_wr_i = 1'b0;
    logic        reg_rd_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;
    logic [1:0]  node_state_o;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam logic [31:0] B_ACT = 32'h1 << 16;
    localparam logic [31:0] B_WRN = 32'h1 << 17;
    localparam logic [31:0] B_PAS = 32'h1 << 18;
    localparam logic [31:0] B_BOF = 32'h1 << 19;

    always #2.5 clk = ~clk;

    can_irq_ctrl i_can_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .mb_ready_i(mb_ready_i), .frame_err_i(frame_err_i),
        .rec_i(rec_i), .tec_i(tec_i), .bus_recover_i(bus_recover_i),
        .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .irq_o(irq_o),
        .node_state_o(node_state_o)
    );

    // Monitor: compare each read result one step after its capturing edge.
    initial begin
        forever begin
            @(posedge clk);
            if (reg_rd_i && rst_n) begin
                #1;
                vectors++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL scoreboard: got %h expected <queued item>", reg_rdata_o);
                end else begin
                    automatic logic [31:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    if (reg_rdata_o !== e) begin
                        fails++;
                        $display("FAIL %s: got %h expected %h", t, reg_rdata_o, e);
                    end
                end
            end
        end
    end

    task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
        reg_addr_i = a;
        reg_rd_i   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        reg_rd_i = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_addr_i  = a;
        reg_wdata_i = d;
        reg_wr_i    = 1'b1;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
        vectors++;
        if (act !== e) begin
            fails++;
            $display("FAIL %s: got %h expected %h", t, act, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk({31'b0, irq_o}, 0, "R1 irq");
        chk({30'b0, node_state_o}, 0, "R1 state");
        rd(3'd2, 32'h0, "R1 mask");
        rd(3'd4, 32'h0, "R1 errcnt");
        rd(3'd3, B_ACT, "R1 status");
        // R2: mailbox levels
        mb_ready_i = 16'hA5A5;
        @(negedge clk);
        rd(3'd3, 32'hA5A5 | B_ACT, "R2 mailbox bits");
        // R3 then R4: sticky flags and clear on read
        frame_err_i = 5'b00101;
        @(negedge clk);
        frame_err_i = '0;
        rd(3'd3, 32'hA5A5 | B_ACT | (32'h1 << 24) | (32'h1 << 26), "R3 sticky set");
        rd(3'd3, 32'hA5A5 | B_ACT, "R4 cleared by read");
        // R5: pulse in the read cycle survives
        frame_err_i = 5'b10000;
        rd(3'd3, 32'hA5A5 | B_ACT, "R5 read excludes same-cycle pulse");
        frame_err_i = '0;
        rd(3'd3, 32'hA5A5 | B_ACT | (32'h1 << 28), "R5 flag kept after read");
        rd(3'd3, 32'hA5A5 | B_ACT, "R4 cleared on next read");
        // R6: set-only and clear-only mask writes
        wr(3'd0, 32'h0100_0001);
        rd(3'd2, 32'h0100_0001, "R6 set");
        wr(3'd0, 32'h0000_0100);
        rd(3'd2, 32'h0100_0101, "R6 set keeps others");
        wr(3'd1, 32'h0000_0001);
        rd(3'd2, 32'h0100_0100, "R6 clear");
        // R7: interrupt line, mask holds bits 8 and 24
        chk({31'b0, irq_o}, 1, "R7 mailbox 8 enabled");
        mb_ready_i = 16'h0001;
        @(negedge clk);
        chk({31'b0, irq_o}, 0, "R7 unmasked source only");
        frame_err_i = 5'b00001;
        @(negedge clk);
        frame_err_i = '0;
        chk({31'b0, irq_o}, 1, "R7 CRC flag enabled");
        rd(3'd3, 32'h0001 | B_ACT | (32'h1 << 24), "R4 read with CRC");
        chk({31'b0, irq_o}, 0, "R7 drops after clear");
        wr(3'd1, 32'h1FFF_FFFF);
        rd(3'd2, 32'h0, "R6 clear all");
        mb_ready_i = '0;
        // R8, R9, R11: counts and derived state
        rec_i = 8'd100; tec_i = 9'd10;
        @(negedge clk);
        rd(3'd4, 32'd100 | (32'd10 << 16), "R8 errcnt");
        rd(3'd3, B_WRN, "R9 warning from rec");
        chk({30'b0, node_state_o}, 1, "R11 warning");
        rec_i = 8'd95; tec_i = 9'd95;
        @(negedge clk);
        rd(3'd3, B_ACT, "R9 just below warning");
        chk({30'b0, node_state_o}, 0, "R11 active");
        rec_i = 8'd128; tec_i = 9'd0;
        @(negedge clk);
        rd(3'd3, B_WRN | B_PAS, "R9 passive at 128");
        rec_i = 8'd5; tec_i = 9'd130;
        @(negedge clk);
        rd(3'd4, 32'd5 | (32'd130 << 16), "R8 errcnt tec");
        chk({30'b0, node_state_o}, 2, "R11 passive");
        // R10: bus-off latch and recovery
        rec_i = 8'd0; tec_i = 9'd256;
        @(negedge clk);
        rd(3'd3, B_WRN | B_PAS | B_BOF, "R10 bus-off set");
        chk({30'b0, node_state_o}, 3, "R11 bus-off");
        rd(3'd4, 32'h0, "R8 tec low byte");
        tec_i = 9'd50;
        @(negedge clk);
        rd(3'd3, B_BOF, "R10 held without recovery");
        chk({30'b0, node_state_o}, 3, "R11 bus-off held");
        tec_i = 9'd300; bus_recover_i = 1'b1;
        @(negedge clk);
        bus_recover_i = 1'b0;
        rd(3'd3, B_WRN | B_PAS | B_BOF, "R10 recovery at limit ignored");
        tec_i = 9'd50; bus_recover_i = 1'b1;
        @(negedge clk);
        bus_recover_i = 1'b0;
        rd(3'd3, B_ACT, "R10 released");
        chk({30'b0, node_state_o}, 0, "R11 active after release");
        repeat (2) @(negedge clk);
        chk(exp_q.size(), 0, "scoreboard drained");
        finish_run();
    end
endmodule